// File: doc/BRIEF.md
# Lens Actuator Control Register Block

This block is the register file on the device side of a voice-coil lens actuator driver. A host reaches it through a simple byte-wide port. Each write carries either an explicit address or a continue flag, and the continue flag makes the write land on the address after the previous write. The block holds a power-down bit and a ringing-control enable, a 10-bit drive-current code split over a high register and a low register, a ringing-mode/prescale register and a vibration-period register. Its outputs are the effective current code, the mode fields and an output-enable.

After reset, and every time the power-down bit is cleared, the block counts an operation delay. Its length is a number of microseconds converted to clock cycles through a clock-frequency parameter. A status bit reads 1 while the delay runs. Writes are always stored. The effective code stays at zero until the block is powered up and the delay has expired. The current code must be written high register first. The high byte is held in a staging register, and the full 10-bit code changes in one step when the low byte arrives.

Top module: `lens_act_regs`

## Requirements
- R1: After reset, register 0x02 reads 0x00, 0x06 reads 0x41 (ringing mode 010, prescale 001), 0x07 reads 0x20, 0x03 and 0x04 read 0x00, dac_code is 0 and busy is 1.
- R2: busy, also readable as bit 0 of register 0x05 with bits 7:1 reading 0, stays 1 for exactly DELAY_US*CLK_HZ/1e6 clock edges after reset and then falls. When it falls with power-down clear, drive_en becomes 1.
- R3: Register 0x02 bit 0 is power-down (1 = powered down) and bit 1 enables ringing control (ring_en output, 0 = direct). Bits 7:2 read 0.
- R4: Register 0x03 bits 1:0 give code bits 9:8 and register 0x04 gives bits 7:0. A write to 0x03 only stages the high bits. The next write to 0x04 commits both parts together, and until then dac_code and the read-back of 0x03 keep their old values.
- R5: A write with wr_cont = 1 ignores addr and goes to the address after the previous write's address.
- R6: While powered down or busy, drive_en is 0 and dac_code is 0. Current-code writes made in that time are stored and appear on dac_code once the block is ready.
- R7: Clearing power-down when it was set restarts busy for the full delay. Setting power-down clears busy at once.
- R8: Register 0x06 stores bits 7:5 (ring_mode) and 2:0 (presc) exactly as written, reserved codes included. Bits 4:3 read 0.
- R9: Register 0x07 stores bits 5:0 (vib_period). Bits 7:6 read 0.
- R10: Addresses other than 0x02-0x07 read 0, and writes to them or to 0x05 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_cont | input | 1 | Write to previous write address + 1 instead of addr |
| addr | input | 8 | Register address for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| dac_code | output | 10 | Effective drive-current code |
| drive_en | output | 1 | Output enable: powered up and not busy |
| ring_en | output | 1 | Ringing-control mode selected |
| ring_mode | output | 3 | Ringing mode field |
| presc | output | 3 | Internal clock prescale field |
| vib_period | output | 6 | Vibration-period setting |
| busy | output | 1 | Operation delay running |

## Verification
The hardest state to reach is a stored code that does not yet drive the output. That state needs a current-code write made while powered down, followed by a power-up and a full delay count before the value may appear. The stimulus sets power-down and writes both bytes through the continue path. It then clears power-down and counts edges to the exact cycle where busy falls, checking that dac_code is zero one cycle before and equals the stored code on that cycle. A high-only write and randomized two-byte writes then show that the code changes only on the low byte.

// File: rtl/lar_pkg.sv
package lar_pkg;
    localparam logic [7:0] A_CTRL = 8'h02;
    localparam logic [7:0] A_DHI  = 8'h03;
    localparam logic [7:0] A_DLO  = 8'h04;
    localparam logic [7:0] A_STAT = 8'h05;
    localparam logic [7:0] A_MODE = 8'h06;
    localparam logic [7:0] A_VIB  = 8'h07;

    localparam logic [2:0] RST_MODE  = 3'b010;
    localparam logic [2:0] RST_PRESC = 3'b001;
    localparam logic [5:0] RST_VIB   = 6'h20;

    typedef struct packed {
        logic       pd;
        logic       ring;
        logic [1:0] hi_stage;
        logic [1:0] hi;
        logic [7:0] lo;
        logic [2:0] mode;
        logic [2:0] presc;
        logic [5:0] vib;
        logic [7:0] ptr;
    } regs_t;
endpackage

// File: rtl/lar_delay.sv
module lar_delay #(
    parameter int CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (stop) begin
            cnt_d = '0;
        end else if (start) begin
            cnt_d = CW'(CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CW'(CYC);
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/lar_rdmux.sv
module lar_rdmux
    import lar_pkg::*;
(
    input  logic [7:0] addr,
    input  regs_t      regs,
    input  logic       busy,
    output logic [7:0] rdata
);
    always_comb begin
        case (addr)
            A_CTRL:  rdata = {6'b0, regs.ring, regs.pd};
            A_DHI:   rdata = {6'b0, regs.hi};
            A_DLO:   rdata = regs.lo;
            A_STAT:  rdata = {7'b0, busy};
            A_MODE:  rdata = {regs.mode, 2'b00, regs.presc};
            A_VIB:   rdata = {2'b00, regs.vib};
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/lens_act_regs.sv
module lens_act_regs
    import lar_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int DELAY_US = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_cont,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [9:0] dac_code,
    output logic       drive_en,
    output logic       ring_en,
    output logic [2:0] ring_mode,
    output logic [2:0] presc,
    output logic [5:0] vib_period,
    output logic       busy
);
    localparam int CYC_PER_US = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
    localparam int DELAY_CYC  = (CYC_PER_US * DELAY_US > 0) ? CYC_PER_US * DELAY_US : 1;

    regs_t      st_d, st_q;
    logic [7:0] eff_addr;
    logic       t_start, t_stop;
    logic       pd_bit;
    logic [9:0] dac_word;

    assign eff_addr = wr_cont ? st_q.ptr : addr;

    always_comb begin
        st_d    = st_q;
        t_start = 1'b0;
        t_stop  = 1'b0;
        if (wr_en) begin
            st_d.ptr = 8'(eff_addr + 8'd1);
            case (eff_addr)
                A_CTRL: begin
                    st_d.pd   = wdata[0];
                    st_d.ring = wdata[1];
                    t_stop    = wdata[0];
                    t_start   = st_q.pd && !wdata[0];
                end
                A_DHI:  st_d.hi_stage = wdata[1:0];
                A_DLO: begin
                    st_d.lo = wdata;
                    st_d.hi = st_q.hi_stage;
                end
                A_MODE: begin
                    st_d.mode  = wdata[7:5];
                    st_d.presc = wdata[2:0];
                end
                A_VIB:  st_d.vib = wdata[5:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pd: 1'b0, ring: 1'b0, hi_stage: 2'b0, hi: 2'b0, lo: 8'h00,
                      mode: RST_MODE, presc: RST_PRESC, vib: RST_VIB, ptr: 8'h00};
        end else begin
            st_q <= st_d;
        end
    end

    lar_delay #(.CYC(DELAY_CYC)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .start (t_start),
        .stop  (t_stop),
        .busy  (busy)
    );

    lar_rdmux u_rdmux (
        .addr  (addr),
        .regs  (st_q),
        .busy  (busy),
        .rdata (rdata)
    );

    assign pd_bit     = st_q.pd;
    assign dac_word   = {st_q.hi, st_q.lo};
    assign drive_en   = !st_q.pd && !busy;
    assign dac_code   = drive_en ? dac_word : 10'd0;
    assign ring_en    = st_q.ring;
    assign ring_mode  = st_q.mode;
    assign presc      = st_q.presc;
    assign vib_period = st_q.vib;
endmodule

// File: rtl/lens_act_regs_chk.sv
module lens_act_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] eff_addr,
    input logic [7:0] wdata,
    input logic [7:0] addr,
    input logic [7:0] rdata,
    input logic       busy,
    input logic       drive_en,
    input logic [9:0] dac_code,
    input logic       pd_bit,
    input logic [9:0] dac_word
);
    // R6
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> dac_code == 10'd0);

    // R7
    pd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && eff_addr == 8'h02 && wdata[0]) |=> (!busy && !drive_en));

    // R7
    pd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && eff_addr == 8'h02 && !wdata[0] && pd_bit) |=> busy);

    // R4
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && eff_addr == 8'h03) |=> $stable(dac_word));

    // R2
    ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !pd_bit) |-> drive_en);

    // R2
    stat_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 8'h05) |-> (rdata[7:1] == 7'd0 && rdata[0] == busy));
endmodule

bind lens_act_regs lens_act_regs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .eff_addr (eff_addr),
    .wdata    (wdata),
    .addr     (addr),
    .rdata    (rdata),
    .busy     (busy),
    .drive_en (drive_en),
    .dac_code (dac_code),
    .pd_bit   (pd_bit),
    .dac_word (dac_word)
);

// File: tb/lens_act_regs_test.sv
module lens_act_regs_test;
    localparam int CLK_HZ   = 2_000_000;
    localparam int DELAY_US = 8;
    localparam int CYC      = (CLK_HZ / 1_000_000) * DELAY_US;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_cont = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [9:0] dac_code;
    logic       drive_en, ring_en, busy;
    logic [2:0] ring_mode, presc;
    logic [5:0] vib_period;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lens_act_regs #(.CLK_HZ(CLK_HZ), .DELAY_US(DELAY_US)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cont(wr_cont),
        .addr(addr), .wdata(wdata), .rdata(rdata), .dac_code(dac_code),
        .drive_en(drive_en), .ring_en(ring_en), .ring_mode(ring_mode),
        .presc(presc), .vib_period(vib_period), .busy(busy)
    );

    function automatic logic [7:0] exp_mode(input logic [7:0] w);
        return w & 8'hE7;
    endfunction

    function automatic logic [7:0] exp_vib(input logic [7:0] w);
        return w & 8'h3F;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic cont);
        wr_en = 1'b1; wr_cont = cont; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_cont = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [9:0] code;
        void'($urandom(32'd7341));
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h02, v); check("R1 ctrl", v, 8'h00);
        rd(8'h06, v); check("R1 mode", v, 8'h41);
        rd(8'h07, v); check("R1 vib", v, 8'h20);
        rd(8'h03, v); check("R1 dhi", v, 0);
        rd(8'h04, v); check("R1 dlo", v, 0);
        check("R1 dac", dac_code, 0);
        check("R1 busy", busy, 1);
        // R2 delay length after reset
        repeat (CYC - 1) @(negedge clk);
        rd(8'h05, v); check("R2 status busy", v, 8'h01);
        check("R2 drive_en low", drive_en, 0);
        @(negedge clk);
        rd(8'h05, v); check("R2 status ready", v, 8'h00);
        check("R2 drive_en", drive_en, 1);
        // R7 set power-down, R6 stored writes while down
        wr(8'h02, 8'h01, 1'b0);
        check("R7 busy cleared", busy, 0);
        check("R6 drive_en off", drive_en, 0);
        wr(8'h03, 8'h02, 1'b0);
        wr(8'h00, 8'h34, 1'b1);            // R5 continues to 0x04
        check("R6 dac zero while down", dac_code, 0);
        rd(8'h03, v); check("R4 hi stored", v, 8'h02);
        rd(8'h04, v); check("R5 lo via continue", v, 8'h34);
        // R7 clear power-down, ringing on: delay restarts
        wr(8'h02, 8'h02, 1'b0);
        check("R7 busy restart", busy, 1);
        check("R3 ring_en", ring_en, 1);
        rd(8'h02, v); check("R3 ctrl readback", v, 8'h02);
        repeat (CYC - 1) @(negedge clk);
        check("R6 dac zero while busy", dac_code, 0);
        @(negedge clk);
        check("R6 stored code appears", dac_code, 10'h234);
        // R4 high byte alone does not change output
        wr(8'h03, 8'h01, 1'b0);
        check("R4 hi staged only", dac_code, 10'h234);
        rd(8'h03, v); check("R4 hi readback old", v, 8'h02);
        wr(8'h04, 8'h00, 1'b0);
        check("R4 commit", dac_code, 10'h100);
        wr(8'h03, 8'h03, 1'b0);
        wr(8'h55, 8'hFF, 1'b1);
        check("R4 R5 max code", dac_code, 10'h3FF);
        // R8 reserved codes stored, bits 4:3 zero
        wr(8'h06, 8'hFF, 1'b0);
        rd(8'h06, v); check("R8 mode readback", v, 8'hE7);
        check("R8 ring_mode", ring_mode, 7);
        check("R8 presc", presc, 7);
        // R9 with R5 continue from 0x06
        wr(8'h00, 8'hFF, 1'b1);
        rd(8'h07, v); check("R9 vib readback", v, 8'h3F);
        check("R9 vib_period", vib_period, 6'h3F);
        // R10 unmapped and status writes ignored
        wr(8'h10, 8'hAA, 1'b0);
        wr(8'h05, 8'hFF, 1'b0);
        wr(8'h01, 8'h03, 1'b0);
        rd(8'h10, v); check("R10 unmapped read", v, 0);
        rd(8'h00, v); check("R10 addr0 read", v, 0);
        rd(8'h02, v); check("R10 ctrl untouched", v, 8'h02);
        rd(8'h05, v); check("R10 status untouched", v, 0);
        check("R10 dac untouched", dac_code, 10'h3FF);
        // randomized two-byte code writes and mode/vib writes
        for (int i = 0; i < 40; i++) begin
            logic [7:0] h, l, m, t;
            h = 8'($urandom);
            l = 8'($urandom);
            m = 8'($urandom);
            t = 8'($urandom);
            code = {h[1:0], l};
            wr(8'h03, h, 1'b0);
            wr(8'h00, l, 1'b1);
            check("R4 random code", dac_code, code);
            wr(8'h06, m, 1'b0);
            wr(8'h00, t, 1'b1);
            rd(8'h06, v); check("R8 random mode", v, exp_mode(m));
            rd(8'h07, v); check("R9 random vib", v, exp_vib(t));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule